// File: doc/BRIEF.md
# Cipher Interrupt Flag Controller

This block keeps the sticky interrupt status of a block-cipher accelerator. Hardware sources outside it (the cipher datapath, the transfer engine and the key storage) report events as single-cycle pulses. Each pulse sets a flag that stays set until software clears it by writing a 1 to the matching bit of a dedicated clear register. The status register itself is read-only.

Three flags are visible to software: computation done, transfer error and key error. The transfer error flag summarises two sub-flags, one for illegal reads and one for illegal writes, and both sub-flags are readable. Each of the three main flags has an enable bit. The single interrupt output is the registered OR of each enabled flag. The done flag stops contributing to the interrupt while the output-transfer engine is enabled, because software does not wait on it in that mode; the flag itself still sets.

Software accesses three registers through a small port with a combinational read path: status at address 0, enable at address 1 and clear at address 2. Address 3 reads as zero.

Top module: `cipher_irq_ctrl`

## Requirements
- R1: After reset, every status bit, every enable bit and `irq_o` are 0.
- R2: A pulse on `evt_done_i` sets status bit 0. The bit can be read in the cycle after the clock edge that samples the pulse.
- R3: Writing to the clear register (address 2) clears each flag whose bit is 1 in the written data (bit 0 done, bit 2 key error). Flags whose bit is 0 keep their value.
- R4: When a set pulse and a clear write for the same flag fall in the same cycle, the flag ends up set.
- R5: A pulse on `evt_rd_err_i` sets status bit 3 and status bit 1. A pulse on `evt_wr_err_i` sets status bit 4 and status bit 1.
- R6: Writing 1 to clear bit 1 clears status bits 1, 3 and 4 together.
- R7: A pulse on `evt_key_err_i` sets status bit 2.
- R8: `irq_o` equals the OR over the done, transfer-error and key-error flags of each flag ANDed with its enable bit (enable bits 0, 1 and 2 at address 1). It is registered, so it follows a change of flag or enable one clock later.
- R9: While `dma_out_en_i` is 1, the done flag still sets but does not assert `irq_o`.
- R10: Writes to the status address change no status bit. The clear register always reads back 0.
- R11: The enable register keeps bits [2:0] of a write and reads back 0 in all higher bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_done_i | input | 1 | Computation finished pulse |
| evt_rd_err_i | input | 1 | Illegal read pulse |
| evt_wr_err_i | input | 1 | Illegal write pulse |
| evt_key_err_i | input | 1 | Key load failure pulse |
| dma_out_en_i | input | 1 | Output-transfer engine enabled |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A flag stuck at the wrong value shows up in the next status read and, when its enable bit is set, on `irq_o` one clock later. An interrupt that is lost is therefore visible within two cycles. The clear logic is checked by reading the status back straight after each clear write. A clear that reaches the wrong flag, or a set that loses to a clear, is visible in that single read. The gating by the transfer engine is checked by toggling `dma_out_en_i` while the done flag stays set and watching `irq_o` follow it one cycle later.

// File: rtl/cipher_irq_pkg.sv
package cipher_irq_pkg;
  localparam int NFLAG   = 3;
  localparam int NSTAT   = NFLAG + 2;
  localparam int FL_DONE = 0;
  localparam int FL_XFER = 1;
  localparam int FL_KEY  = 2;
  localparam int SB_RD   = 3;
  localparam int SB_WR   = 4;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] A_EN   = 2'd1;
  localparam logic [ADDR_W-1:0] A_CLR  = 2'd2;

  // Per-flag contribution to the interrupt; done is masked while the output engine runs.
  function automatic logic [NFLAG-1:0] irq_terms(input logic [NFLAG-1:0] flags,
                                                 input logic [NFLAG-1:0] en,
                                                 input logic dma_on);
    logic [NFLAG-1:0] t;
    t = flags & en;
    if (dma_on) t[FL_DONE] = 1'b0;
    return t;
  endfunction

  // Map clear-register bits onto all status bits (transfer clear hits its sub-flags too).
  function automatic logic [NSTAT-1:0] clr_spread(input logic [NFLAG-1:0] c);
    logic [NSTAT-1:0] s;
    s = '0;
    s[NFLAG-1:0] = c;
    s[SB_RD] = c[FL_XFER];
    s[SB_WR] = c[FL_XFER];
    return s;
  endfunction
endpackage

// File: rtl/cipher_irq_flag.sv
module cipher_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  a_r3_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  a_r3_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/cipher_irq_regs.sv
module cipher_irq_regs
  import cipher_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSTAT-1:0]  status_i,
  output logic [NFLAG-1:0]  en_o,
  output logic [NFLAG-1:0]  clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic wr_en_hit;
  logic wr_clr_hit;
  logic unused_wdata_hi;

  assign wr_en_hit       = wr_i && (addr_i == A_EN);
  assign wr_clr_hit      = wr_i && (addr_i == A_CLR);
  assign clr_o           = {NFLAG{wr_clr_hit}} & wdata_i[NFLAG-1:0];
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:NFLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_o <= '0;
    else if (wr_en_hit) en_o <= wdata_i[NFLAG-1:0];
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_STAT:  rdata_o[NSTAT-1:0] = status_i;
      A_EN:    rdata_o[NFLAG-1:0] = en_o;
      default: rdata_o = '0;
    endcase
  end

  a_r10_clear_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CLR) |-> (rdata_o == '0));
  a_r11_enable_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_hit |=> $stable(en_o));
endmodule

// File: rtl/cipher_irq_combine.sv
module cipher_irq_combine
  import cipher_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] flags_i,
  input  logic [NFLAG-1:0] en_i,
  input  logic             dma_on_i,
  output logic             irq_o
);
  logic [NFLAG-1:0] terms;
  assign terms = irq_terms(flags_i, en_i, dma_on_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |terms;
  end

  a_r8_quiet_without_enabled_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_i & en_i) == '0) |=> !irq_o);
  a_r8_key_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i[FL_KEY] && en_i[FL_KEY]) |=> irq_o);
  a_r9_dma_masks_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_on_i && ((flags_i[NFLAG-1:1] & en_i[NFLAG-1:1]) == '0)) |=> !irq_o);
endmodule

// File: rtl/cipher_irq_ctrl.sv
module cipher_irq_ctrl
  import cipher_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_done_i,
  input  logic              evt_rd_err_i,
  input  logic              evt_wr_err_i,
  input  logic              evt_key_err_i,
  input  logic              dma_out_en_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [NSTAT-1:0] stat_set;
  logic [NSTAT-1:0] stat_clr;
  logic [NSTAT-1:0] status;
  logic [NFLAG-1:0] flag_en;
  logic [NFLAG-1:0] clr_req;
  logic             any_evt;

  always_comb begin
    stat_set          = '0;
    stat_set[FL_DONE] = evt_done_i;
    stat_set[FL_XFER] = evt_rd_err_i | evt_wr_err_i;
    stat_set[FL_KEY]  = evt_key_err_i;
    stat_set[SB_RD]   = evt_rd_err_i;
    stat_set[SB_WR]   = evt_wr_err_i;
  end

  assign stat_clr = clr_spread(clr_req);
  assign any_evt  = |stat_set;

  for (genvar i = 0; i < NSTAT; i++) begin : g_flag
    cipher_irq_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (stat_set[i]),
      .clr_i  (stat_clr[i]),
      .q_o    (status[i])
    );
  end

  cipher_irq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (reg_addr_i),
    .wr_i     (reg_wr_i),
    .wdata_i  (reg_wdata_i),
    .status_i (status),
    .en_o     (flag_en),
    .clr_o    (clr_req),
    .rdata_o  (reg_rdata_o)
  );

  cipher_irq_combine u_comb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flags_i  (status[NFLAG-1:0]),
    .en_i     (flag_en),
    .dma_on_i (dma_out_en_i),
    .irq_o    (irq_o)
  );

  a_r10_status_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == A_STAT && !any_evt) |=> $stable(status));
  a_r5_sub_implies_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status[SB_RD] || status[SB_WR]) |-> status[FL_XFER]);
  a_r6_summary_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req[FL_XFER] && !evt_rd_err_i && !evt_wr_err_i) |=> (status[FL_XFER] == 1'b0 && status[SB_RD] == 1'b0 && status[SB_WR] == 1'b0));
endmodule

// File: tb/cipher_irq_ctrl_bench.sv
module cipher_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_done = 0, ev_rd = 0, ev_wr = 0, ev_key = 0, dma = 0;
  logic [1:0]    addr = 0;
  logic          wr = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  int            n_checks = 0;
  int            n_fail = 0;
  bit            finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cipher_irq_ctrl #(.DATA_W(DW)) u_cipher_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_done_i(ev_done), .evt_rd_err_i(ev_rd), .evt_wr_err_i(ev_wr),
    .evt_key_err_i(ev_key), .dma_out_en_i(dma),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0; wdata = '0;
  endtask

  task automatic pulse(input logic d, input logic r, input logic w, input logic k);
    @(negedge clk);
    ev_done = d; ev_rd = r; ev_wr = w; ev_key = k;
    @(negedge clk);
    ev_done = 0; ev_rd = 0; ev_wr = 0; ev_key = 0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    rd(2'd0, v); check("R1 status", v, 0);
    rd(2'd1, v); check("R1 enable", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_done_and_clear;
    logic [DW-1:0] v;
    pulse(1, 0, 0, 0);
    rd(2'd0, v); check("R2 done set", v, 32'h1);
    pulse(0, 0, 0, 1);
    rd(2'd0, v); check("R7 key set", v, 32'h5);
    wr_reg(2'd2, 32'h4);
    rd(2'd0, v); check("R3 key cleared, done kept", v, 32'h1);
    wr_reg(2'd2, 32'h0);
    rd(2'd0, v); check("R3 zero write keeps", v, 32'h1);
    wr_reg(2'd2, 32'h1);
    rd(2'd0, v); check("R3 done cleared", v, 32'h0);
  endtask

  task automatic t_set_wins;
    logic [DW-1:0] v;
    @(negedge clk);
    ev_done = 1; addr = 2'd2; wdata = 32'h1; wr = 1;
    @(negedge clk);
    ev_done = 0; wr = 0; wdata = '0;
    rd(2'd0, v); check("R4 set beats clear", v, 32'h1);
    wr_reg(2'd2, 32'h1);
    rd(2'd0, v); check("R4 cleanup", v, 32'h0);
  endtask

  task automatic t_xfer;
    logic [DW-1:0] v;
    pulse(0, 1, 0, 0);
    rd(2'd0, v); check("R5 read error", v, 32'h0A);
    pulse(0, 0, 1, 0);
    rd(2'd0, v); check("R5 write error", v, 32'h1A);
    wr_reg(2'd2, 32'h2);
    rd(2'd0, v); check("R6 all three cleared", v, 32'h0);
    pulse(0, 0, 1, 0);
    rd(2'd0, v); check("R5 write only", v, 32'h12);
    wr_reg(2'd2, 32'h2);
  endtask

  task automatic t_irq;
    logic [DW-1:0] v;
    pulse(0, 0, 0, 1);
    @(negedge clk);
    check("R8 disabled no irq", {31'b0, irq}, 0);
    wr_reg(2'd1, 32'h4);
    check("R8 irq lags enable", {31'b0, irq}, 0);
    @(negedge clk);
    check("R8 irq raised", {31'b0, irq}, 1);
    wr_reg(2'd2, 32'h4);
    @(negedge clk);
    check("R8 irq drops", {31'b0, irq}, 0);
    wr_reg(2'd1, 32'h2);
    pulse(0, 1, 0, 0);
    @(negedge clk);
    check("R8 xfer irq", {31'b0, irq}, 1);
    wr_reg(2'd2, 32'h2);
    @(negedge clk);
    check("R8 xfer irq drops", {31'b0, irq}, 0);
    rd(2'd0, v); check("R8 status clear", v, 0);
  endtask

  task automatic t_dma;
    logic [DW-1:0] v;
    wr_reg(2'd1, 32'h1);
    dma = 1;
    pulse(1, 0, 0, 0);
    rd(2'd0, v); check("R9 done still sets", v, 32'h1);
    @(negedge clk);
    check("R9 irq masked", {31'b0, irq}, 0);
    dma = 0;
    @(negedge clk);
    check("R9 irq after unmask", {31'b0, irq}, 1);
    wr_reg(2'd2, 32'h1);
    @(negedge clk);
  endtask

  task automatic t_status_wr;
    logic [DW-1:0] v;
    wr_reg(2'd0, 32'hFF);
    rd(2'd0, v); check("R10 write to status ignored", v, 0);
    pulse(0, 0, 0, 1);
    wr_reg(2'd0, 32'h0);
    rd(2'd0, v); check("R10 status held", v, 32'h4);
    rd(2'd2, v); check("R10 clear reads 0", v, 0);
    rd(2'd3, v); check("R10 spare reads 0", v, 0);
    wr_reg(2'd2, 32'h7);
  endtask

  task automatic t_enable_rw;
    logic [DW-1:0] v;
    wr_reg(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R11 enable masked", v, 32'h7);
    wr_reg(2'd1, 32'h5);
    rd(2'd1, v); check("R11 enable value", v, 32'h5);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_done_and_clear;
    t_set_wins;
    t_xfer;
    t_irq;
    t_dma;
    t_status_wr;
    t_enable_rw;
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule